// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block connects a processor whose address and data share one 32-bit bus to a memory-side port that has separate address, byte-enable, write-data and read-data signals. A transfer opens with an address phase. While the latch strobe `ale` is high, the bus carries the upper address in its high bits and the byte-lane enables in its low four bits. The block captures both, together with the transfer direction and the burst request.

In the data phase that follows, the block presents a full word address on every cycle. It also tracks which word of the transfer is in flight. A single-word transfer uses the 2-bit word index that the processor supplies with the latch strobe. A burst read ignores that index, starts at word zero and moves exactly four words. Write data flows from the shared bus to the memory port. Read data flows back onto the shared bus only in the cycle the memory acknowledges it. In every other cycle the block's bus drivers stay off. A one-cycle completion pulse marks the end of each transfer, and in that same cycle the block can accept the next address.

Top module: `mux_bus_demux`

## Requirements
- R1: A synchronous active-high `rst` clears the latched address, byte enables and word index and forces `mem_req`, `ad_oe` and `done` to 0. While `rst` is held and on the first cycle after it is released, `mem_addr` and `mem_be` read 0.
- R2: When `ale` is high in an idle cycle, the block captures `ad_in[31:4]` and `ad_in[3:0]` (active-high byte enables, bit n selects byte lane n). From the next cycle, `mem_req` is 1, `mem_addr[31:4]` equals the captured bits, `mem_addr[1:0]` is 0 and `mem_be` equals the captured enables.
- R3: For a single-word transfer, `mem_addr[3:2]` equals the value of `low_addr` sampled with `ale`. Later changes on `low_addr` have no effect.
- R4: A read with `burst`=1 at the latch strobe moves four words. `mem_addr[3:2]` is 0 for the first word and advances by one on each `mem_ack`, whatever value `low_addr` had.
- R5: During a write data phase `mem_we` is 1 and `mem_wdata` equals `ad_in`. During a read data phase `mem_we` is 0.
- R6: `ad_oe` is 1 only in a read data phase cycle with `mem_ack` high, and `ad_out` then equals `mem_rdata`. In every other cycle `ad_oe` is 0.
- R7: `done` is high for exactly one cycle, the cycle after the acknowledge of the last word (the only word of a single transfer, the fourth word of a burst). `mem_req` is 0 in that cycle, and `mem_addr` and `mem_be` hold steady between acknowledges.
- R8: `ale` is ignored while a data phase is in progress. The address, enables and word index stay unchanged.
- R9: A write with `burst`=1 is treated as a single-word transfer at the `low_addr` word index.
- R10: A new `ale` in the cycle where `done` is high is accepted, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address-phase latch strobe |
| rd | input | 1 | Transfer is a read (sampled with `ale`) |
| burst | input | 1 | Four-word burst request (sampled with `ale`) |
| low_addr | input | 2 | Word index for single transfers (sampled with `ale`) |
| ad_in | input | 32 | Shared bus as seen by the block |
| ad_out | output | 32 | Read data the block places on the shared bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| mem_req | output | 1 | Data phase active, word address valid |
| mem_we | output | 1 | Current word is a write |
| mem_addr | output | 32 | Full byte address of the current word |
| mem_be | output | 4 | Byte-lane enables of the transfer |
| mem_wdata | output | 32 | Write data toward memory |
| mem_rdata | input | 32 | Read data from memory |
| mem_ack | input | 1 | Memory completes the current word |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high. They also assume that the processor drives write data onto `ad_in` for the whole write data phase. The bench raises `mem_ack` only after it has seen a data phase open, and drives the store word from the cycle after the latch strobe. For reads it leaves `ad_in` at a harmless value, except in the cycles where it deliberately places a stray address with `ale` to show that the strobe is ignored.

// File: rtl/mux_bus_demux_pkg.sv
package mux_bus_demux_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/mbd_phase_ctrl.sv
module mbd_phase_ctrl
    import mux_bus_demux_pkg::*;
#(
    parameter int HI_W      = 28,
    parameter int BE_W      = 4,
    parameter int BURST_LEN = 4,
    parameter int IDX_W     = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ale,
    input  logic             rd,
    input  logic             burst,
    input  logic [IDX_W-1:0] low_idx,
    input  logic [HI_W-1:0]  bus_hi,
    input  logic [BE_W-1:0]  bus_be,
    input  logic             ack,
    output logic             active,
    output logic             is_read,
    output logic [HI_W-1:0]  hi_addr,
    output logic [BE_W-1:0]  be,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

    typedef struct packed {
        phase_e           phase;
        logic [HI_W-1:0]  hi;
        logic [BE_W-1:0]  be;
        logic [IDX_W-1:0] idx;
        logic             rd;
        logic             bst;
        logic             done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (ale) begin
                    st_d.phase = PH_DATA;
                    st_d.hi    = bus_hi;
                    st_d.be    = bus_be;
                    st_d.rd    = rd;
                    st_d.bst   = burst & rd;
                    st_d.idx   = (burst & rd) ? '0 : low_idx;
                end
            end
            PH_DATA: begin
                if (ack) begin
                    if (!st_q.bst || st_q.idx == LAST_IDX) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, hi: '0, be: '0, idx: '0,
                      rd: 1'b0, bst: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = (st_q.phase == PH_DATA);
    assign is_read = st_q.rd;
    assign hi_addr = st_q.hi;
    assign be      = st_q.be;
    assign idx     = st_q.idx;
    assign done    = st_q.done;
endmodule

// File: rtl/mbd_data_route.sv
module mbd_data_route #(
    parameter int DATA_W = 32
) (
    input  logic              active,
    input  logic              is_read,
    input  logic              ack,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] wdata
);
    always_comb begin
        bus_oe  = active & is_read & ack;
        bus_out = bus_oe ? rdata : '0;
        wdata   = bus_in;
    end
endmodule

// File: rtl/mux_bus_demux.sv
module mux_bus_demux #(
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 4,
    parameter int BE_W      = DATA_W / 8,
    parameter int IDX_W     = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              rd,
    input  logic              burst,
    input  logic [IDX_W-1:0]  low_addr,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              done
);
    localparam int OFF_W = $clog2(BE_W);
    localparam int HI_W  = DATA_W - OFF_W - IDX_W;

    logic              active, is_read;
    logic [HI_W-1:0]   hi_addr;
    logic [IDX_W-1:0]  idx;

    mbd_phase_ctrl #(
        .HI_W(HI_W), .BE_W(BE_W), .BURST_LEN(BURST_LEN), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ale    (ale),
        .rd     (rd),
        .burst  (burst),
        .low_idx(low_addr),
        .bus_hi (ad_in[DATA_W-1 -: HI_W]),
        .bus_be (ad_in[BE_W-1:0]),
        .ack    (mem_ack),
        .active (active),
        .is_read(is_read),
        .hi_addr(hi_addr),
        .be     (mem_be),
        .idx    (idx),
        .done   (done)
    );

    mbd_data_route #(.DATA_W(DATA_W)) u_route (
        .active (active),
        .is_read(is_read),
        .ack    (mem_ack),
        .bus_in (ad_in),
        .rdata  (mem_rdata),
        .bus_out(ad_out),
        .bus_oe (ad_oe),
        .wdata  (mem_wdata)
    );

    assign mem_req  = active;
    assign mem_we   = active & ~is_read;
    assign mem_addr = {hi_addr, idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/mux_bus_demux_chk.sv
module mux_bus_demux_chk #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_addr,
    input logic [BE_W-1:0]   mem_be,
    input logic              ad_oe,
    input logic              done
);
    localparam int OFF_W = $clog2(BE_W);
    localparam int LO    = OFF_W;
    localparam int HI    = OFF_W + IDX_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!mem_req && !ad_oe && !done));

    assert_drive_only_read_ack_R6: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (mem_req && !mem_we && mem_ack));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_req && $past(mem_req && mem_ack)));

    assert_hold_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

    assert_word_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=>
            (done || (mem_addr[HI-1:LO] == $past(mem_addr[HI-1:LO]) + IDX_W'(1))));

    assert_hi_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=>
            (done || mem_addr[DATA_W-1:HI] == $past(mem_addr[DATA_W-1:HI])));
endmodule

bind mux_bus_demux mux_bus_demux_chk #(
    .DATA_W(DATA_W), .BE_W(BE_W), .IDX_W(IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .mem_be  (mem_be),
    .ad_oe   (ad_oe),
    .done    (done)
);

// File: tb/mux_bus_demux_test.sv
module mux_bus_demux_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0, rd = 1'b0, burst = 1'b0;
    logic [1:0]  low_addr = 2'b00;
    logic [31:0] ad_in = '0, mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] ad_out, mem_addr, mem_wdata;
    logic        ad_oe, mem_req, mem_we, done;
    logic [3:0]  mem_be;

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be;
        logic        we;
        logic [31:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    mux_bus_demux uut (
        .clk(clk), .rst(rst), .ale(ale), .rd(rd), .burst(burst),
        .low_addr(low_addr), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops one expected word per acknowledged data cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && mem_req && mem_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", mem_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.addr, "R2/R3/R4 mem_addr", mem_addr, e.addr);
                    chk(mem_be == e.be, "R2 mem_be", {28'h0, mem_be}, {28'h0, e.be});
                    chk(mem_we == e.we, "R5 mem_we", {31'h0, mem_we}, {31'h0, e.we});
                    if (e.we) begin
                        chk(mem_wdata == e.data, "R5 mem_wdata", mem_wdata, e.data);
                        chk(!ad_oe, "R6 oe on write", {31'h0, ad_oe}, 32'h0);
                    end else begin
                        chk(ad_oe, "R6 oe on read ack", {31'h0, ad_oe}, 32'h1);
                        chk(ad_out == e.data, "R6 ad_out", ad_out, e.data);
                    end
                end
            end
        end
    end

    // driver: starts at negedge+1, returns at negedge+1 after the done pulse
    task automatic do_xfer(input logic [27:0] hi, input logic [3:0] be,
                           input bit rd_t, input bit bst, input logic [1:0] low,
                           input int gap, input bit junk);
        int nw;
        nw = (bst && rd_t) ? 4 : 1;
        ale = 1'b1; ad_in = {hi, be}; rd = rd_t; burst = bst;
        low_addr = low; mem_ack = 1'b0;
        @(negedge clk);
        ale = 1'b0; burst = ~bst; rd = ~rd_t; low_addr = ~low;
        for (int w = 0; w < nw; w++) begin
            exp_t e;
            logic [1:0] ix;
            ix = (bst && rd_t) ? 2'(w) : low;
            e.addr = {hi, ix, 2'b00};
            e.be   = be;
            e.we   = !rd_t;
            e.data = {hi[15:0], 8'(w), 4'h0, be} ^ 32'h5A00_0000;
            exp_q.push_back(e);
            ad_in = rd_t ? 32'h0 : e.data;
            for (int g = 0; g < gap; g++) begin
                if (junk && rd_t) begin
                    ale = 1'b1;
                    ad_in = 32'hF0F0_F0FF;
                end
                #1;
                chk(!ad_oe, "R6 oe without ack", {31'h0, ad_oe}, 32'h0);
                chk(!done, "R7 done early", {31'h0, done}, 32'h0);
                @(negedge clk);
            end
            ale = 1'b0;
            if (rd_t) ad_in = 32'h0;
            mem_rdata = e.data;
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            if (w < nw - 1) begin
                #1;
                chk(!done && mem_req, "R4/R7 mid-burst", {30'h0, done, mem_req}, 32'h1);
            end
        end
        #1;
        chk(done, "R7 done pulse", {31'h0, done}, 32'h1);
        chk(!mem_req, "R7 req drops", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
        chk(!done && !mem_req, "R7 idle after pulse", {30'h0, done, mem_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!mem_req && !ad_oe && !done, "R1 reset outputs",
            {29'h0, mem_req, ad_oe, done}, 32'h0);
        chk(mem_addr == 0 && mem_be == 0, "R1 reset address", mem_addr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!mem_req && mem_addr == 0, "R1 after release", mem_addr, 32'h0);
        // R2/R3 single read, immediate ack
        do_xfer(28'h123_4567, 4'b1111, 1, 0, 2'd2, 0, 0);
        idle(2);
        // R5 single write with wait cycles, R3 index 1
        do_xfer(28'hABC_DEF0, 4'b0011, 0, 0, 2'd1, 2, 0);
        idle(1);
        // R4 burst read, low_addr 3 ignored
        do_xfer(28'h000_0F00, 4'b1000, 1, 1, 2'd3, 1, 0);
        // R10 back to back: R9 burst write becomes single at index 2
        do_xfer(28'h765_4321, 4'b0101, 0, 1, 2'd2, 0, 0);
        // R10 then R8 stray ale during a burst
        do_xfer(28'hFFF_FFFF, 4'b1100, 1, 1, 2'd1, 2, 1);
        // R8 stray ale during a single read
        do_xfer(28'h0AA_5500, 4'b0001, 1, 0, 2'd3, 1, 1);
        idle(1);
        // R4 burst with no waits, R3 single read index 0
        do_xfer(28'h135_7924, 4'b0110, 1, 1, 2'd2, 0, 0);
        do_xfer(28'h246_8ACE, 4'b1111, 1, 0, 2'd0, 3, 0);
        idle(3);
        chk(exp_q.size() == 0, "R2 all words seen", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end
endmodule